// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the configuration port of a larger chip. An external controller drives a serial clock line and a serial data line, and the block answers on a third line of its own, an output that carries both the acknowledge and any data read back. Because nothing is shared on a bidirectional wire, the answer line is a plain push-pull output.

A transfer opens with a start condition and carries whole bytes, most significant bit first. Each byte takes nine serial clocks, and the ninth is the acknowledge slot. The first byte holds the device identity and the direction. In the write direction, the next byte loads a register pointer and every byte after that is stored at the pointer, which then advances. In the read direction, bytes are returned from the pointer, which advances the same way. Read data leaves inverted. The pointer wraps around the 128-entry space. The lowest 124 entries are writable registers, exposed in parallel to the rest of the chip. The top four entries reflect status inputs and cannot be written.

Both serial lines are brought into the system clock domain through a two-flop synchroniser. All bus events are recognised from the synchronised samples.

Top module: `sreg_slave`

## Requirements
- R1: When the data line falls while the serial clock is high, a new transfer opens. This happens in any state, and the answer line goes low.
- R2: When the data line rises while the serial clock is high, the transfer closes and the answer line goes low. Serial clocks that follow are ignored until the next start.
- R3: Bytes are shifted in on rising serial clock edges, MSB first. When a byte is accepted, the answer line goes high on the falling edge of its eighth clock. The answer line changes only on a serial clock edge, a start or a stop.
- R4: The device byte 24h selects the write direction and 25h selects the read direction; both are acknowledged. Any other device byte gets no acknowledge, and the rest of that transfer changes no register.
- R5: In a write, the byte after the device byte sets the pointer from its low 7 bits. Each byte after that is stored at the pointer, and the pointer then advances by one. There is no limit on the byte count.
- R6: The pointer wraps from 7Fh to 00h, in both directions.
- R7: In a read, the answer line carries the inverse of the addressed byte, MSB first. The first bit appears at the falling edge of the device byte's ninth clock. Each later bit appears at the falling edge of the previous data clock. During the ninth clock of a data byte the line is low, and the pointer advances.
- R8: In the write direction, the acknowledge stays high through the ninth clock and after it. It is released at the next rising serial clock edge: the first bit of the next byte, or a dummy clock before a stop.
- R9: Entries 7Ch to 7Fh read back status byte k = entry - 7Ch, which is status_in[8k+7:8k]. A write to these entries is acknowledged and advances the pointer, but changes no register.
- R10: A serial line change takes effect on the third rising system clock edge after it. An acknowledge started by a falling serial clock is first visible after that edge.
- R11: Asynchronous reset clears all writable registers to 00h, clears the pointer to 00h, drives the answer line low and returns the link to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_dat | input | 1 | Serial data from the controller |
| ser_ans | output | 1 | Acknowledge and inverted read data |
| status_in | input | 32 | Four read-only status bytes, byte k at bits 8k+7:8k |
| regs_out | output | 992 | Writable registers, entry n at bits 8n+7:8n |

## Verification
On every cycle the assertions check several things. The answer line moves only on a serial clock edge or a bus condition, and it is low right after a start or a stop. Each pointer step adds exactly one, modulo 128. A register write lands at the addressed entry, and the register bank is otherwise frozen. Some behaviour can only be shown by the bench's scenarios, because it depends on whole transfers. These are the device byte decode and the ignored transfer that follows a mismatch, the acknowledge hold until the dummy clock, inverted MSB-first read-back across the status entries and the wrap, and the exact three-cycle synchroniser latency.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_DEVICE,
    LNK_POINTER,
    LNK_WRITE,
    LNK_READ,
    LNK_SKIP
  } lnk_state_e;

  localparam int unsigned BITS_PER_BYTE = 8;
  localparam logic [3:0]  SLOT_CNT      = 4'd9;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sreg_link.sv
module sreg_link
  import sreg_pkg::*;
#(
  parameter int unsigned AW      = 7,
  parameter int unsigned DW      = 8,
  parameter logic [6:0]  DEV_ID  = 7'h12,
  parameter int unsigned RO_BASE = 124
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic          ans,
  output logic          start_det,
  output logic          stop_det,
  output logic          sck_rise,
  output logic          sck_fall,
  output logic          wr_en,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] wr_data,
  output logic          ptr_step
);
  lnk_state_e    state_q;
  logic          sck_q, sdi_q;
  logic [3:0]    cnt_q;
  logic [DW-1:0] shreg_q, rdbyte_q;
  logic [AW-1:0] ptr_q;
  logic          byte_done;
  logic [2:0]    bit_sel;

  assign start_det = sck_s && sck_q && sdi_q && !sdi_s;
  assign stop_det  = sck_s && sck_q && !sdi_q && sdi_s;
  assign sck_rise  = sck_s && !sck_q;
  assign sck_fall  = !sck_s && sck_q;
  assign byte_done = sck_fall && (cnt_q == 4'd8) && (state_q != LNK_IDLE);
  assign wr_en     = byte_done && (state_q == LNK_WRITE) && (ptr_q < AW'(RO_BASE));
  assign ptr_step  = byte_done && ((state_q == LNK_WRITE) || (state_q == LNK_READ));
  assign ptr       = ptr_q;
  assign wr_data   = shreg_q;
  assign bit_sel   = 3'd7 - cnt_q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      sdi_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      sdi_q <= sdi_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LNK_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      rdbyte_q <= '0;
      ptr_q    <= '0;
      ans      <= 1'b0;
    end else if (start_det) begin
      state_q <= LNK_DEVICE;
      cnt_q   <= '0;
      ans     <= 1'b0;
    end else if (stop_det) begin
      state_q <= LNK_IDLE;
      cnt_q   <= '0;
      ans     <= 1'b0;
    end else if (state_q != LNK_IDLE) begin
      if (sck_rise) begin
        if (cnt_q == 4'd8) begin
          cnt_q <= SLOT_CNT;
        end else begin
          cnt_q   <= (cnt_q == SLOT_CNT) ? 4'd1 : cnt_q + 4'd1;
          shreg_q <= {shreg_q[DW-2:0], sdi_s};
          if (state_q != LNK_READ) ans <= 1'b0;
        end
      end else if (sck_fall) begin
        if (cnt_q == 4'd8) begin
          unique case (state_q)
            LNK_DEVICE: begin
              if (shreg_q == {DEV_ID, 1'b0}) begin
                state_q <= LNK_POINTER;
                ans     <= 1'b1;
              end else if (shreg_q == {DEV_ID, 1'b1}) begin
                state_q <= LNK_READ;
                ans     <= 1'b1;
              end else begin
                state_q <= LNK_SKIP;
                ans     <= 1'b0;
              end
            end
            LNK_POINTER: begin
              ptr_q   <= shreg_q[AW-1:0];
              state_q <= LNK_WRITE;
              ans     <= 1'b1;
            end
            LNK_WRITE: begin
              ptr_q <= ptr_q + 1'b1;
              ans   <= 1'b1;
            end
            LNK_READ: begin
              ptr_q <= ptr_q + 1'b1;
              ans   <= 1'b0;
            end
            default: ans <= 1'b0;
          endcase
        end else if (state_q == LNK_READ) begin
          if (cnt_q == SLOT_CNT) begin
            rdbyte_q <= rd_data;
            ans      <= ~rd_data[DW-1];
          end else if (cnt_q != 4'd0) begin
            ans <= ~rdbyte_q[bit_sel];
          end
        end
      end
    end
  end
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
  parameter int unsigned NREG = 128,
  parameter int unsigned NRO  = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned NRW = NREG - NRO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NRO*DW-1:0] status_in,
  output logic [NRW*DW-1:0] regs_out
);
  logic [DW-1:0] view [NREG];

  generate
    for (genvar i = 0; i < NRW; i++) begin : g_rw
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else if (wr_en && (wr_addr == AW'(i))) cell_q <= wr_data;
      end
      assign regs_out[i*DW +: DW] = cell_q;
      assign view[i] = cell_q;
    end
    for (genvar k = 0; k < NRO; k++) begin : g_ro
      assign view[NRW+k] = status_in[k*DW +: DW];
    end
  endgenerate

  assign rd_data = view[rd_addr];
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
  parameter int unsigned NREG   = 128,
  parameter int unsigned NRO    = 4,
  parameter int unsigned DW     = 8,
  parameter logic [6:0]  DEV_ID = 7'h12,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned NRW = NREG - NRO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              ser_ans,
  input  logic [NRO*DW-1:0] status_in,
  output logic [NRW*DW-1:0] regs_out
);
  logic [1:0]    lines_s;
  logic          start_det, stop_det, sck_rise, sck_fall;
  logic          wr_en, ptr_step;
  logic [AW-1:0] ptr;
  logic [DW-1:0] wr_data, rd_data;

  sreg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_clk, ser_dat}),
    .sync_out (lines_s)
  );

  sreg_link #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID), .RO_BASE(NRW)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (lines_s[1]),
    .sdi_s     (lines_s[0]),
    .rd_data   (rd_data),
    .ans       (ser_ans),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .wr_en     (wr_en),
    .ptr       (ptr),
    .wr_data   (wr_data),
    .ptr_step  (ptr_step)
  );

  sreg_regfile #(.NREG(NREG), .NRO(NRO), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (ptr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .status_in (status_in),
    .regs_out  (regs_out)
  );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk #(
  parameter int unsigned AW  = 7,
  parameter int unsigned DW  = 8,
  parameter int unsigned NRW = 124
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_ans,
  input logic              start_det,
  input logic              stop_det,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              wr_en,
  input logic [AW-1:0]     ptr,
  input logic [DW-1:0]     wr_data,
  input logic              ptr_step,
  input logic [NRW*DW-1:0] regs_out
);
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_addr <= ptr;
      last_data <= wr_data;
    end
  end

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !ser_ans); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !ser_ans); // R2
  AST_ANS_ON_EVENTS: assert property (@(posedge clk) disable iff (!rst_n) !(sck_rise || sck_fall || start_det || stop_det) |=> $stable(ser_ans)); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) ptr_step |=> ptr == $past(ptr) + 1'b1); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> regs_out[last_addr*DW +: DW] == last_data); // R5
  AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs_out)); // R9
endmodule

bind sreg_slave sreg_slave_chk #(.AW(AW), .DW(DW), .NRW(NRW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_ans   (ser_ans),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sck_rise  (sck_rise),
  .sck_fall  (sck_fall),
  .wr_en     (wr_en),
  .ptr       (ptr),
  .wr_data   (wr_data),
  .ptr_step  (ptr_step),
  .regs_out  (regs_out)
);

// File: tb/sreg_slave_bench.sv
module sreg_slave_bench;
  localparam int NREG = 128;
  localparam int NRO  = 4;
  localparam int DW   = 8;
  localparam int NRW  = NREG - NRO;
  localparam int HOLD = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ser_clk = 1'b1;
  logic              ser_dat = 1'b1;
  logic              ser_ans;
  logic [NRO*DW-1:0] status_in = 32'hC3B2A190;
  logic [NRW*DW-1:0] regs_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sreg_slave u_sreg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .ser_ans   (ser_ans),
    .status_in (status_in),
    .regs_out  (regs_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int a);
    return regs_out[a*DW +: DW];
  endfunction

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic put(input logic c, input logic d);
    @(negedge clk);
    ser_clk = c;
    ser_dat = d;
    hold();
  endtask

  task automatic bus_start();
    put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    put(1'b1, 1'b0);
    put(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input bit is_read_dev, input bit lat_chk);
    for (int i = 7; i >= 0; i--) begin
      put(1'b0, b[i]);
      put(1'b1, b[i]);
      if (i > 0) put(1'b0, b[i]);
    end
    @(negedge clk);
    ser_clk = 1'b0;
    if (lat_chk) begin
      @(negedge clk);
      @(negedge clk);
      chk(ser_ans == 1'b0, "R10 not yet after two edges", ser_ans, 0);
      @(negedge clk);
      chk(ser_ans == exp_ack, "R10 visible after third edge", ser_ans, exp_ack);
    end
    hold();
    chk(ser_ans == exp_ack, "R3/R4 ack after eighth clock", ser_ans, exp_ack);
    put(1'b1, ser_dat);
    chk(ser_ans == exp_ack, "R8 ack during ninth clock", ser_ans, exp_ack);
    put(1'b0, ser_dat);
    if (!is_read_dev) chk(ser_ans == exp_ack, "R8 ack held after ninth clock", ser_ans, exp_ack);
  endtask

  task automatic dummy_clock();
    put(1'b1, ser_dat);
    chk(ser_ans == 1'b0, "R8 dummy clock releases ack", ser_ans, 0);
    put(1'b0, ser_dat);
  endtask

  task automatic recv_byte(input logic [7:0] exp);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      got[i] = ~ser_ans;
      put(1'b1, ser_dat);
      put(1'b0, ser_dat);
    end
    chk(ser_ans == 1'b0, "R7 line low in ninth slot", ser_ans, 0);
    put(1'b1, ser_dat);
    put(1'b0, ser_dat);
    chk(got == exp, "R7 inverted MSB-first read byte", got, exp);
  endtask

  task automatic t_reset();
    logic all_zero;
    all_zero = (regs_out == '0);
    chk(ser_ans == 1'b0, "R11 answer low after reset", ser_ans, 0);
    chk(all_zero, "R11 registers cleared", all_zero, 1);
  endtask

  task automatic t_single_write();
    bus_start();
    chk(ser_ans == 1'b0, "R1 answer low at start", ser_ans, 0);
    send_byte(8'h24, 1'b1, 1'b0, 1'b1);
    send_byte(8'h05, 1'b1, 1'b0, 1'b0);
    send_byte(8'hA5, 1'b1, 1'b0, 1'b0);
    dummy_clock();
    bus_stop();
    chk(reg_at(5) == 8'hA5, "R5 single write lands", reg_at(5), 8'hA5);
    chk(reg_at(4) == 8'h00 && reg_at(6) == 8'h00, "R5 neighbours untouched", {reg_at(4), reg_at(6)}, 0);
  endtask

  task automatic t_burst_wrap();
    bus_start();
    send_byte(8'h24, 1'b1, 1'b0, 1'b0);
    send_byte(8'h7A, 1'b1, 1'b0, 1'b0);
    send_byte(8'h11, 1'b1, 1'b0, 1'b0);
    send_byte(8'h22, 1'b1, 1'b0, 1'b0);
    send_byte(8'h33, 1'b1, 1'b0, 1'b0);
    send_byte(8'h44, 1'b1, 1'b0, 1'b0);
    send_byte(8'h55, 1'b1, 1'b0, 1'b0);
    send_byte(8'h66, 1'b1, 1'b0, 1'b0);
    send_byte(8'h77, 1'b1, 1'b0, 1'b0);
    dummy_clock();
    bus_stop();
    chk(reg_at(122) == 8'h11 && reg_at(123) == 8'h22, "R5 burst increments", {reg_at(122), reg_at(123)}, 16'h1122);
    chk(reg_at(0) == 8'h77, "R6 write wraps to 00h", reg_at(0), 8'h77);
    chk(reg_at(1) == 8'h00, "R9 read-only writes dropped", reg_at(1), 0);
  endtask

  task automatic t_wrong_device();
    logic [NRW*DW-1:0] snap;
    logic same;
    snap = regs_out;
    bus_start();
    send_byte(8'h30, 1'b0, 1'b0, 1'b0);
    send_byte(8'h05, 1'b0, 1'b0, 1'b0);
    send_byte(8'hEE, 1'b0, 1'b0, 1'b0);
    bus_stop();
    same = (regs_out == snap);
    chk(same, "R4 mismatched device changes nothing", same, 1);
  endtask

  task automatic t_read();
    bus_start();
    send_byte(8'h24, 1'b1, 1'b0, 1'b0);
    send_byte(8'h05, 1'b1, 1'b0, 1'b0);
    dummy_clock();
    bus_stop();
    bus_start();
    send_byte(8'h25, 1'b1, 1'b1, 1'b0);
    recv_byte(8'hA5);
    recv_byte(8'h00);
    bus_stop();
    chk(ser_ans == 1'b0, "R2 stop releases answer", ser_ans, 0);
  endtask

  task automatic t_read_status();
    bus_start();
    send_byte(8'h24, 1'b1, 1'b0, 1'b0);
    send_byte(8'h7E, 1'b1, 1'b0, 1'b0);
    bus_start();
    send_byte(8'h25, 1'b1, 1'b1, 1'b0);
    recv_byte(8'hB2);
    recv_byte(8'hC3);
    recv_byte(8'h77);
    bus_stop();
    chk(ser_ans == 1'b0, "R9 line low after status read", ser_ans, 0);
  endtask

  task automatic t_after_stop();
    logic [NRW*DW-1:0] snap;
    logic same;
    logic [7:0] pat;
    snap = regs_out;
    pat = 8'h24;
    for (int i = 7; i >= 0; i--) begin
      put(1'b0, pat[i]);
      put(1'b1, pat[i]);
    end
    put(1'b0, 1'b0);
    chk(ser_ans == 1'b0, "R2 clocks ignored after stop", ser_ans, 0);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
    same = (regs_out == snap);
    chk(same, "R2 no change while idle", same, 1);
  endtask

  task automatic t_reset_mid();
    logic all_zero;
    bus_start();
    send_byte(8'h24, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    all_zero = (regs_out == '0);
    chk(ser_ans == 1'b0, "R11 reset drops answer", ser_ans, 0);
    chk(all_zero, "R11 reset clears registers", all_zero, 1);
    ser_clk = 1'b1;
    ser_dat = 1'b1;
    hold();
    rst_n = 1'b1;
    hold();
    bus_start();
    send_byte(8'h25, 1'b1, 1'b1, 1'b0);
    recv_byte(8'h00);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hold();
    t_single_write();
    t_burst_wrap();
    t_wrong_device();
    t_read();
    t_read_status();
    t_after_stop();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule